// File: doc/BRIEF.md
# Byte-Wide EPROM Control Model with Identifier Readout

This block is a synthesizable, clocked model of the control logic of a byte-wide ultraviolet-erasable read-only memory, meant as a test target inside a larger verification environment. On every clock edge it samples two active-low strobes (`ce_n`, `oe_n`) and two flags for high voltage. `vpp_hi` marks the programming voltage on the output-enable pin. `id_hi` marks the identifier voltage on address line 9. From these it picks one operating mode. It then drives the data bus with its tri-state enable, or programs a byte of its internal array.

The array is a register memory of `DEPTH` bytes. Reset fills it with all ones, which stands in for an erase. Programming can only clear bits: the stored byte becomes the old value AND the bus data. When `id_hi` is set and every address line other than lines 0 and 9 is low, a read returns one of two fixed identifier bytes instead of array data. Both identifier bytes carry odd parity, with bit 7 as the parity bit.

The mode register holds six states: `MD_STANDBY`, `MD_READ`, `MD_OUT_OFF`, `MD_PROGRAM`, `MD_INHIBIT` and `MD_IDENT`. Every state can move to every other state on the next edge. The target is decided by the sampled pins in priority order:
- `vpp_hi` with `ce_n` low goes to `MD_PROGRAM`.
- `vpp_hi` with `ce_n` high goes to `MD_INHIBIT`.
- `ce_n` high goes to `MD_STANDBY`.
- `oe_n` high goes to `MD_OUT_OFF`.
- The identifier address pattern goes to `MD_IDENT`.
- Any other pin combination goes to `MD_READ`.

Program verify is `MD_READ` entered after a programming cycle. Reset forces `MD_STANDBY`.

Top module: `eprom_ctrl`

## Requirements
- R1: While reset is low and after it is released, every array byte reads FFh, and `dout_en` and `dout` are 0 until a read is requested.
- R2: With `ce_n`=0, `oe_n`=0 and `vpp_hi`=0, and the identifier pattern absent, the clock edge after sampling sets `dout_en`=1 and `dout` to the stored byte.
- R3: With `ce_n`=0, `oe_n`=1 and `vpp_hi`=0, the next edge sets `dout_en`=0 and `dout`=00h, even when the identifier pattern is present.
- R4: With `ce_n`=1 and `vpp_hi`=0, the next edge sets `dout_en`=0 and `dout`=00h, whatever the values of `oe_n` and `id_hi`.
- R5: With `vpp_hi`=1 and `ce_n`=0, the edge stores old AND `din` into the addressed byte and sets `dout_en`=0. `id_hi` does not change this. A following read returns the ANDed value.
- R6: With `vpp_hi`=1 and `ce_n`=1, no byte changes and `dout_en`=0.
- R7: With `id_hi`=1, `addr[15:1]` zero apart from bit 9, and a read strobe, the output is 01h when `addr[0]`=0 and 91h when `addr[0]`=1.
- R8: Each identifier byte has an odd number of ones, with bit 7 used as the parity bit.
- R9: With `id_hi`=1 and any address line other than lines 0 and 9 high, a read returns array data.
- R10: A program cycle never changes a 0 bit to 1. Programming FFh over 05h leaves 05h.
- R11: The array uses only the low log2(`DEPTH`) address bits, so higher address bits alias onto the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; erases the array to all ones |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming voltage present on the output-enable pin |
| id_hi | input | 1 | Identifier voltage present on address line 9 |
| addr | input | 16 | Byte address |
| din | input | 8 | Data to program |
| dout | output | 8 | Read data; 00h while not driving |
| dout_en | output | 1 | Tri-state enable for `dout` |

## Verification
The assertions assume that the pins are sampled cleanly at the clock edge. They also assume that `vpp_hi` and `id_hi` are plain logic flags that can be raised in any combination with the strobes. The bench changes inputs only at the falling edge and reads the outputs one falling edge later, so each check sees exactly one sampled pin set. The stimulus reaches every mode, including the cases where several flags are set together. Examples are programming with `id_hi` set and the identifier pattern under an output-disable strobe. In each case the priority order above decides the outcome.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // Lines that must be low for identifier readout: all but 0 and 9.
    localparam logic [ADDR_W-1:0] ID_QUIET_MASK = ~(ADDR_W'(1) | (ADDR_W'(1) << 9));

    localparam logic [DATA_W-1:0] MFR_CODE = 8'h01;
    localparam logic [DATA_W-1:0] DEV_CODE = 8'h91;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_READ,
        MD_OUT_OFF,
        MD_PROGRAM,
        MD_INHIBIT,
        MD_IDENT
    } eprom_mode_e;

endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
    import eprom_pkg::*;
(
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              id_hi,
    input  logic [ADDR_W-1:0] addr,
    output eprom_mode_e       mode
);

    logic id_pattern;

    assign id_pattern = id_hi && ((addr & ID_QUIET_MASK) == '0);

    always_comb begin
        unique casez ({vpp_hi, ce_n, oe_n})
            3'b10?:  mode = MD_PROGRAM;
            3'b11?:  mode = MD_INHIBIT;
            3'b01?:  mode = MD_STANDBY;
            3'b001:  mode = MD_OUT_OFF;
            3'b000:  mode = id_pattern ? MD_IDENT : MD_READ;
            default: mode = MD_STANDBY;
        endcase
    end

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array
    import eprom_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] rd_o
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (prog_i) begin
            cells[idx_i] <= cells[idx_i] & din_i;
        end
    end

    assign rd_o = cells[idx_i];

    // R10
    no_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_i |=> ((cells[$past(idx_i)] & ~$past(rd_o)) == '0));

endmodule

// File: rtl/eprom_id_sel.sv
module eprom_id_sel
    import eprom_pkg::*;
(
    input  logic              dev_sel,
    output logic [DATA_W-1:0] id_byte
);

    assign id_byte = dev_sel ? DEV_CODE : MFR_CODE;

endmodule

// File: rtl/eprom_ctrl.sv
module eprom_ctrl
    import eprom_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              id_hi,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    eprom_mode_e       cur_mode;
    eprom_mode_e       next_mode;
    logic [DATA_W-1:0] cell_byte;
    logic [DATA_W-1:0] id_byte;
    logic              prog_now;

    eprom_mode_decode u_decode (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_hi (vpp_hi),
        .id_hi  (id_hi),
        .addr   (addr),
        .mode   (next_mode)
    );

    assign prog_now = (next_mode == MD_PROGRAM);

    eprom_cell_array #(.DEPTH(DEPTH)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .prog_i (prog_now),
        .idx_i  (addr[IDX_W-1:0]),
        .din_i  (din),
        .rd_o   (cell_byte)
    );

    eprom_id_sel u_id (
        .dev_sel (addr[0]),
        .id_byte (id_byte)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_mode <= MD_STANDBY;
        end else begin
            cur_mode <= next_mode;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            unique case (next_mode)
                MD_READ: begin
                    dout    <= cell_byte;
                    dout_en <= 1'b1;
                end
                MD_IDENT: begin
                    dout    <= id_byte;
                    dout_en <= 1'b1;
                end
                MD_STANDBY, MD_OUT_OFF, MD_PROGRAM, MD_INHIBIT: begin
                    dout    <= '0;
                    dout_en <= 1'b0;
                end
                default: begin
                    dout    <= '0;
                    dout_en <= 1'b0;
                end
            endcase
        end
    end

    // R2
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !vpp_hi) |=> dout_en);

    // R3
    out_off_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && !vpp_hi) |=> (!dout_en && dout == '0));

    // R4
    standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !vpp_hi) |=> (!dout_en && dout == '0));

    // R6
    prog_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_hi |=> !dout_en);

    // R7
    mfr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !vpp_hi && id_hi && (addr & ID_QUIET_MASK) == '0 && !addr[0])
        |=> (dout == 8'h01));

    // R8
    id_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MD_IDENT) |-> (^dout));

endmodule

// File: tb/eprom_ctrl_bench.sv
`timescale 1ns/1ps
module eprom_ctrl_bench;

    localparam int DEPTH = 16;
    localparam int NVEC  = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        vpp_hi = 1'b0;
    logic        id_hi = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    eprom_ctrl #(.DEPTH(DEPTH)) u_eprom_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
        .id_hi(id_hi), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    // {ce_n, oe_n, vpp_hi, id_hi, addr[15:0], din[7:0], exp_en, exp_dout[7:0], tag[3:0]}
    function automatic logic [40:0] mk(input logic ce, input logic oe, input logic vp,
                                       input logic ih, input logic [15:0] a,
                                       input logic [7:0] d, input logic en,
                                       input logic [7:0] x, input logic [3:0] t);
        return {ce, oe, vp, ih, a, d, en, x, t};
    endfunction

    localparam logic [40:0] VEC [NVEC] = '{
        mk(0,0,0,0,16'h0000,8'h00,1,8'hFF,4'd1),   // R1 erased
        mk(1,0,0,0,16'h0000,8'h00,0,8'h00,4'd4),   // R4
        mk(1,1,0,0,16'h0002,8'h00,0,8'h00,4'd4),   // R4
        mk(0,1,0,0,16'h0002,8'h00,0,8'h00,4'd3),   // R3
        mk(0,1,1,0,16'h0002,8'hA5,0,8'h00,4'd5),   // R5 program
        mk(0,0,0,0,16'h0002,8'h00,1,8'hA5,4'd5),   // R5 verify
        mk(0,1,1,0,16'h0002,8'h0F,0,8'h00,4'd5),
        mk(0,0,0,0,16'h0002,8'h00,1,8'h05,4'd5),
        mk(0,1,1,0,16'h0002,8'hFF,0,8'h00,4'd10),  // R10
        mk(0,0,0,0,16'h0002,8'h00,1,8'h05,4'd10),
        mk(1,1,1,0,16'h0003,8'h00,0,8'h00,4'd6),   // R6 inhibit
        mk(0,0,0,0,16'h0003,8'h00,1,8'hFF,4'd6),
        mk(0,0,0,1,16'h0000,8'h00,1,8'h01,4'd7),   // R7
        mk(0,0,0,1,16'h0001,8'h00,1,8'h91,4'd7),
        mk(0,1,1,0,16'h0005,8'h3C,0,8'h00,4'd5),
        mk(0,0,0,1,16'h0005,8'h00,1,8'h3C,4'd9),   // R9
        mk(0,0,0,1,16'h8001,8'h00,1,8'hFF,4'd9),
        mk(0,1,0,1,16'h0000,8'h00,0,8'h00,4'd3),   // R3 with id pattern
        mk(0,1,1,1,16'h0000,8'h7E,0,8'h00,4'd5),   // R5 with id_hi
        mk(0,0,0,0,16'h0000,8'h00,1,8'h7E,4'd5),
        mk(0,0,0,1,16'h0000,8'h00,1,8'h01,4'd7),
        mk(0,1,1,0,16'h0013,8'h81,0,8'h00,4'd11),  // R11 alias
        mk(0,0,0,0,16'h0003,8'h00,1,8'h81,4'd11),
        mk(0,0,0,0,16'h0013,8'h00,1,8'h81,4'd11),
        mk(1,0,0,1,16'h0001,8'h00,0,8'h00,4'd4)    // R4 with id
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            4'd10:   return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic en_exp, input logic [7:0] d_exp);
        vectors++;
        if (dout_en !== en_exp || dout !== d_exp) begin
            miscompares++;
            $display("FAIL %s: actual en=%0b dout=%02h expected en=%0b dout=%02h",
                     req, dout_en, dout, en_exp, d_exp);
        end
    endtask

    task automatic apply(input logic ce, input logic oe, input logic vp, input logic ih,
                         input logic [15:0] a, input logic [7:0] d);
        ce_n = ce; oe_n = oe; vpp_hi = vp; id_hi = ih; addr = a; din = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 8'h00);  // outputs idle during reset
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][40], VEC[i][39], VEC[i][38], VEC[i][37],
                  VEC[i][36:21], VEC[i][20:13]);
            check(tag_name(VEC[i][3:0]), VEC[i][12], VEC[i][11:4]);
        end

        // R2: plain read after programming, a second address
        apply(0,0,0,0,16'h0005,8'h00);
        check("R2", 1'b1, 8'h3C);

        // R8: identifier parity computed from the observed bytes
        for (int k = 0; k < 2; k++) begin
            apply(0,0,0,1,16'(k),8'h00);
            vectors++;
            if (^dout !== 1'b1 || dout_en !== 1'b1) begin
                miscompares++;
                $display("FAIL R8: actual dout=%02h parity=%0b expected odd parity", dout, ^dout);
            end
        end

        // R1: reset mid-run erases the array
        ce_n = 1'b1; oe_n = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 1'b0, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        apply(0,0,0,0,16'h0002,8'h00);
        check("R1", 1'b1, 8'hFF);
        apply(0,0,0,0,16'h0003,8'h00);
        check("R1", 1'b1, 8'hFF);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog (R1..all): actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule